// File: doc/BRIEF.md
# Chiplet Control Register Bank

This block holds a set of 64-bit control, configuration and housekeeping words behind a simple register bus. Each bus cycle carries a register index (the byte offset divided by eight), a read strobe, a write strobe and 64-bit write data. Only full-word accesses exist. Eight of the words (six control words and two configuration words) are reachable at three indices each. The base index replaces the word. An index 0x10 above the base ORs the write data into it. An index 0x20 above the base clears the bits that are set in the write data.

The set and clear indices are write-only. Reading them returns all ones and raises a one-cycle error pulse. Four further words (status, mask, protect mode and atomic lock) are plain read/write registers placed sparsely in the index space. Any other index is unmapped. A read of an unmapped index returns all ones. A write to one is dropped. Both raise a separate one-cycle pulse. Read data is registered, so it appears one cycle after the strobe.

Top module: `ctl_reg_bank`

## Requirements
- R1: While rst_n is low and after it is released, every register reads zero and rvalid, err_wo_rd and err_unmapped are low.
- R2: A write to a base index replaces the whole word, and a later read of that index returns it. Control words use bases 0x00..0x05 and configuration words use 0x08 and 0x09.
- R3: A write to base+0x10 (0x10..0x15, 0x18, 0x19) sets the addressed word to its old value OR the write data.
- R4: A write to base+0x20 (0x20..0x25, 0x28, 0x29) sets the addressed word to its old value AND NOT the write data.
- R5: Status (0x100), mask (0x101), protect mode (0x3FE) and atomic lock (0x3FF) are plain read/write registers. A write replaces the value and a read returns it.
- R6: A read of a set or clear index returns rdata all ones with rvalid high and err_wo_rd high for exactly one cycle. No register changes.
- R7: A read of an unmapped index returns all ones with err_unmapped high for one cycle. A write to an unmapped index changes no register and raises err_unmapped for one cycle.
- R8: rvalid and rdata appear exactly one cycle after each read strobe, for one cycle per strobe. Back-to-back reads give back-to-back results, and rvalid is low in every other cycle.
- R9: When read and write strobes are high in the same cycle, only the write is performed: rvalid and err_wo_rd stay low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe (wins over req_rd) |
| req_idx | input | 10 | Register index (byte offset >> 3) |
| req_wdata | input | 64 | Write data |
| rdata | output | 64 | Registered read data, meaningful when rvalid is high |
| rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| err_wo_rd | output | 1 | Pulse: a write-only alias was read |
| err_unmapped | output | 1 | Pulse: an unmapped index was accessed |

## Verification
A write updates the register on the edge that samples it, so its effect is first visible through a read strobed in the following cycle. rdata, rvalid and both error pulses are due one cycle after the strobe that caused them. The bench drives each access on the falling edge. It advances its reference model at the same moment and compares all outputs shortly after the next rising edge, so each expectation is checked in exactly the cycle it is due. Because the comparison runs every cycle, including idle ones, a stray or stretched rvalid or error pulse is also caught.

// File: rtl/ctl_bank_pkg.sv
package ctl_bank_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } bus_op_e;

  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_LOAD = 2'd1,
    UPD_SET  = 2'd2,
    UPD_CLR  = 2'd3
  } upd_e;

  typedef struct packed {
    logic valid;
    logic wo_err;
    logic um_err;
  } rsp_flags_t;

  // write has priority over read in the same cycle
  function automatic bus_op_e classify_op(logic rd, logic wr);
    if (wr)      return OP_WRITE;
    else if (rd) return OP_READ;
    else         return OP_NONE;
  endfunction

endpackage

// File: rtl/ctl_idx_decode.sv
module ctl_idx_decode #(
  parameter int unsigned IDX_W    = 10,
  parameter int unsigned N_CTRL   = 6,
  parameter int unsigned N_CFG    = 2,
  parameter int unsigned CFG_BASE = 8,
  parameter int unsigned SET_OFS  = 16,
  parameter int unsigned CLR_OFS  = 32,
  parameter int unsigned N_PLAIN  = 4,
  parameter logic [N_PLAIN-1:0][IDX_W-1:0] PLAIN_IDX = {10'h3FF, 10'h3FE, 10'h101, 10'h100},
  localparam int unsigned N_ALIAS = N_CTRL + N_CFG
) (
  input  logic [IDX_W-1:0]   idx,
  output logic [N_ALIAS-1:0] hit_dir,
  output logic [N_ALIAS-1:0] hit_set,
  output logic [N_ALIAS-1:0] hit_clr,
  output logic [N_PLAIN-1:0] hit_plain,
  output logic               any_alias,
  output logic               any_hit
);

  for (genvar s = 0; s < N_ALIAS; s++) begin : g_alias
    localparam int unsigned BASE = (s < N_CTRL) ? s : CFG_BASE + s - N_CTRL;
    assign hit_dir[s] = (idx == IDX_W'(BASE));
    assign hit_set[s] = (idx == IDX_W'(BASE + SET_OFS));
    assign hit_clr[s] = (idx == IDX_W'(BASE + CLR_OFS));
  end

  for (genvar p = 0; p < N_PLAIN; p++) begin : g_plain
    assign hit_plain[p] = (idx == PLAIN_IDX[p]);
  end

  assign any_alias = (|hit_set) | (|hit_clr);
  assign any_hit   = any_alias | (|hit_dir) | (|hit_plain);

endmodule

// File: rtl/ctl_bank_word.sv
module ctl_bank_word
  import ctl_bank_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter bit          ALIASED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  upd_e              upd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] q_nxt;
  logic              q_en;

  if (ALIASED) begin : g_alias_upd
    always_comb begin
      unique case (upd)
        UPD_LOAD: q_nxt = wdata;
        UPD_SET:  q_nxt = q | wdata;
        UPD_CLR:  q_nxt = q & ~wdata;
        default:  q_nxt = q;
      endcase
    end
  end else begin : g_plain_upd
    always_comb begin
      q_nxt = (upd == UPD_LOAD) ? wdata : q;
    end
  end

  assign q_en = (upd != UPD_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_en) begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/ctl_read_mux.sv
module ctl_read_mux #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned N_ALIAS = 8,
  parameter int unsigned N_PLAIN = 4
) (
  input  logic [N_ALIAS-1:0]             sel_alias,
  input  logic [N_PLAIN-1:0]             sel_plain,
  input  logic [N_ALIAS-1:0][DATA_W-1:0] alias_q,
  input  logic [N_PLAIN-1:0][DATA_W-1:0] plain_q,
  output logic [DATA_W-1:0]              data,
  output logic                           hit
);

  // AND-OR selection: selects are one-hot from the decoder
  always_comb begin
    data = '0;
    for (int s = 0; s < N_ALIAS; s++) begin
      data = data | (alias_q[s] & {DATA_W{sel_alias[s]}});
    end
    for (int p = 0; p < N_PLAIN; p++) begin
      data = data | (plain_q[p] & {DATA_W{sel_plain[p]}});
    end
  end

  assign hit = (|sel_alias) | (|sel_plain);

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_bank_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned IDX_W    = 10,
  parameter int unsigned N_CTRL   = 6,
  parameter int unsigned N_CFG    = 2,
  parameter int unsigned CFG_BASE = 8,
  parameter int unsigned SET_OFS  = 16,
  parameter int unsigned CLR_OFS  = 32,
  parameter int unsigned N_PLAIN  = 4,
  parameter logic [N_PLAIN-1:0][IDX_W-1:0] PLAIN_IDX = {10'h3FF, 10'h3FE, 10'h101, 10'h100}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              err_wo_rd,
  output logic              err_unmapped
);

  localparam int unsigned N_ALIAS = N_CTRL + N_CFG;

  bus_op_e                      op;
  logic [N_ALIAS-1:0]           hit_dir, hit_set, hit_clr;
  logic [N_PLAIN-1:0]           hit_plain;
  logic                         any_alias, any_hit;
  logic [N_ALIAS-1:0][DATA_W-1:0] alias_q;
  logic [N_PLAIN-1:0][DATA_W-1:0] plain_q;
  logic [DATA_W-1:0]            mux_data;
  logic                         mux_hit;
  rsp_flags_t                   rsp_nxt, rsp_q;
  logic [DATA_W-1:0]            rdata_nxt, rdata_q;
  logic                         rdata_en;

  assign op = classify_op(req_rd, req_wr);

  ctl_idx_decode #(
    .IDX_W(IDX_W), .N_CTRL(N_CTRL), .N_CFG(N_CFG), .CFG_BASE(CFG_BASE),
    .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS), .N_PLAIN(N_PLAIN), .PLAIN_IDX(PLAIN_IDX)
  ) dec_i (
    .idx       (req_idx),
    .hit_dir   (hit_dir),
    .hit_set   (hit_set),
    .hit_clr   (hit_clr),
    .hit_plain (hit_plain),
    .any_alias (any_alias),
    .any_hit   (any_hit)
  );

  for (genvar s = 0; s < N_ALIAS; s++) begin : g_aword
    upd_e upd;
    always_comb begin
      upd = UPD_HOLD;
      if (op == OP_WRITE) begin
        if (hit_dir[s])      upd = UPD_LOAD;
        else if (hit_set[s]) upd = UPD_SET;
        else if (hit_clr[s]) upd = UPD_CLR;
      end
    end
    ctl_bank_word #(.DATA_W(DATA_W), .ALIASED(1'b1)) word_i (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (upd),
      .wdata (req_wdata),
      .q     (alias_q[s])
    );
  end

  for (genvar p = 0; p < N_PLAIN; p++) begin : g_pword
    upd_e upd;
    assign upd = ((op == OP_WRITE) && hit_plain[p]) ? UPD_LOAD : UPD_HOLD;
    ctl_bank_word #(.DATA_W(DATA_W), .ALIASED(1'b0)) word_i (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (upd),
      .wdata (req_wdata),
      .q     (plain_q[p])
    );
  end

  ctl_read_mux #(.DATA_W(DATA_W), .N_ALIAS(N_ALIAS), .N_PLAIN(N_PLAIN)) rmux_i (
    .sel_alias (hit_dir),
    .sel_plain (hit_plain),
    .alias_q   (alias_q),
    .plain_q   (plain_q),
    .data      (mux_data),
    .hit       (mux_hit)
  );

  // response next state
  always_comb begin
    rsp_nxt.valid  = (op == OP_READ);
    rsp_nxt.wo_err = (op == OP_READ) && any_alias;
    rsp_nxt.um_err = (op != OP_NONE) && !any_hit;
    rdata_nxt      = mux_hit ? mux_data : '1;
    rdata_en       = (op == OP_READ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= '0;
    end else begin
      rsp_q <= rsp_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_nxt;
    end
  end

  assign rdata        = rdata_q;
  assign rvalid       = rsp_q.valid;
  assign err_wo_rd    = rsp_q.wo_err;
  assign err_unmapped = rsp_q.um_err;

endmodule

// File: rtl/ctl_reg_bank_chk.sv
module ctl_reg_bank_chk #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned N_ALIAS = 8,
  parameter int unsigned N_PLAIN = 4,
  parameter int unsigned SET_OFS = 16,
  parameter int unsigned CLR_OFS = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           req_rd,
  input logic                           req_wr,
  input logic [IDX_W-1:0]               req_idx,
  input logic [DATA_W-1:0]              req_wdata,
  input logic [DATA_W-1:0]              rdata,
  input logic                           rvalid,
  input logic                           err_wo_rd,
  input logic                           err_unmapped,
  input logic [N_ALIAS-1:0][DATA_W-1:0] alias_q,
  input logic [N_PLAIN-1:0][DATA_W-1:0] plain_q
);

  assert_set_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && req_idx == IDX_W'(SET_OFS)) |=>
      (alias_q[0] == ($past(alias_q[0]) | $past(req_wdata))));

  assert_clr_andnot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && req_idx == IDX_W'(CLR_OFS)) |=>
      (alias_q[0] == ($past(alias_q[0]) & ~$past(req_wdata))));

  assert_read_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !req_wr) |=> ($stable(alias_q) && $stable(plain_q)));

  assert_wo_all_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_wo_rd |-> (rvalid && rdata == {DATA_W{1'b1}}));

  assert_wo_only_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_rd && !req_wr) |=> !err_wo_rd);

  assert_um_all_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_unmapped && rvalid) |-> (rdata == {DATA_W{1'b1}}));

  assert_err_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_wo_rd, err_unmapped}));

  assert_rvalid_due_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !req_wr) |=> rvalid);

  assert_rvalid_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_rd && !req_wr) |=> !rvalid);

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && req_wr) |=> (!rvalid && !err_wo_rd));

endmodule

bind ctl_reg_bank ctl_reg_bank_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .N_ALIAS(N_ALIAS), .N_PLAIN(N_PLAIN),
  .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr), .req_idx(req_idx),
  .req_wdata(req_wdata), .rdata(rdata), .rvalid(rvalid), .err_wo_rd(err_wo_rd),
  .err_unmapped(err_unmapped), .alias_q(alias_q), .plain_q(plain_q)
);

// File: tb/ctl_reg_bank_tb.sv
`timescale 1ns/1ps
module ctl_reg_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_rd, req_wr;
  logic [9:0]  req_idx;
  logic [63:0] req_wdata;
  logic [63:0] rdata;
  logic        rvalid, err_wo_rd, err_unmapped;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [63:0] mdl [int];

  always #4 clk = ~clk;

  ctl_reg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
    .req_idx(req_idx), .req_wdata(req_wdata), .rdata(rdata), .rvalid(rvalid),
    .err_wo_rd(err_wo_rd), .err_unmapped(err_unmapped)
  );

  function automatic bit is_base(int i);
    return (i >= 0 && i <= 5) || i == 8 || i == 9;
  endfunction
  function automatic bit is_plain(int i);
    return i == 256 || i == 257 || i == 1022 || i == 1023;
  endfunction
  function automatic bit is_set(int i);
    return i >= 16 && is_base(i - 16);
  endfunction
  function automatic bit is_clr(int i);
    return i >= 32 && is_base(i - 32);
  endfunction
  function automatic logic [63:0] mget(int i);
    return mdl.exists(i) ? mdl[i] : 64'd0;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, model advances, compare after next posedge
  task automatic step(bit rd, bit wr, int idx, logic [63:0] wd, string tag);
    bit          e_v, e_wo, e_um;
    logic [63:0] e_d;
    @(negedge clk);
    req_rd = rd; req_wr = wr; req_idx = idx[9:0]; req_wdata = wd;
    e_v  = rd && !wr;
    e_wo = e_v && (is_set(idx) || is_clr(idx));
    e_um = (rd || wr) && !(is_base(idx) || is_plain(idx) || is_set(idx) || is_clr(idx));
    e_d  = (is_base(idx) || is_plain(idx)) ? mget(idx) : '1;
    if (wr) begin
      if (is_base(idx) || is_plain(idx)) mdl[idx] = wd;
      else if (is_set(idx))              mdl[idx-16] = mget(idx-16) | wd;
      else if (is_clr(idx))              mdl[idx-32] = mget(idx-32) & ~wd;
    end
    @(posedge clk);
    #2;
    chk(tag, "rvalid", {63'd0, rvalid}, {63'd0, e_v});
    chk(tag, "err_wo_rd", {63'd0, err_wo_rd}, {63'd0, e_wo});
    chk(tag, "err_unmapped", {63'd0, err_unmapped}, {63'd0, e_um});
    if (e_v) chk(tag, $sformatf("rdata@%h", idx), rdata, e_d);
  endtask

  task automatic rd(int idx, string tag);
    step(1'b1, 1'b0, idx, 64'd0, tag);
  endtask
  task automatic wr(int idx, logic [63:0] d, string tag);
    step(1'b0, 1'b1, idx, d, tag);
  endtask
  task automatic idle(string tag);
    step(1'b0, 1'b0, 0, 64'd0, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int mapped[$] = '{0,1,2,3,4,5,8,9,256,257,1022,1023};
    int pool[$]   = '{0,1,2,3,4,5,8,9,16,17,18,19,20,21,24,25,32,33,34,35,36,37,40,41,
                      256,257,1022,1023,6,10,22,47,258,512,1021};
    req_rd = 0; req_wr = 0; req_idx = '0; req_wdata = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1: outputs quiet in reset
    chk("R1", "rvalid in reset", {63'd0, rvalid}, 64'd0);
    chk("R1", "err_wo_rd in reset", {63'd0, err_wo_rd}, 64'd0);
    chk("R1", "err_unmapped in reset", {63'd0, err_unmapped}, 64'd0);
    @(negedge clk); rst_n = 1;
    foreach (mapped[k]) rd(mapped[k], "R1");

    // R2: direct writes
    for (int i = 0; i < 6; i++) wr(i, 64'h1111_0000_0000_0000 * (i + 1) + 64'hA5, "R2");
    wr(8, 64'hDEAD_BEEF_0BAD_F00D, "R2");
    wr(9, 64'h0123_4567_89AB_CDEF, "R2");
    for (int i = 0; i < 6; i++) rd(i, "R2");
    rd(8, "R2"); rd(9, "R2");
    wr(3, 64'hFFFF_FFFF_0000_0001, "R2"); rd(3, "R2");

    // R3: set aliases
    wr(16 + 2, 64'h0000_00F0_0000_0F00, "R3"); rd(2, "R3");
    wr(24, 64'h8000_0000_0000_0001, "R3"); rd(8, "R3");
    wr(16, 64'h0, "R3"); rd(0, "R3");
    wr(25, 64'hFFFF_FFFF_FFFF_FFFF, "R3"); rd(9, "R3");

    // R4: clear aliases
    wr(35, 64'hFFFF_0000_0000_0000, "R4"); rd(3, "R4");
    wr(41, 64'h0000_0000_FFFF_0000, "R4"); rd(9, "R4");
    wr(16 + 5, 64'h00FF_00FF_00FF_00FF, "R4");
    wr(32 + 5, 64'h000F_000F_000F_000F, "R4"); rd(5, "R4");

    // R5: plain registers
    wr(256, 64'h5555_AAAA_5555_AAAA, "R5");
    wr(257, 64'h0F0F_0F0F_F0F0_F0F0, "R5");
    wr(1022, 64'h1, "R5");
    wr(1023, 64'h8000_0000_0000_0000, "R5");
    rd(256, "R5"); rd(257, "R5"); rd(1022, "R5"); rd(1023, "R5");

    // R6: read of write-only aliases, state unchanged
    rd(16, "R6"); rd(37, "R6"); rd(25, "R6"); rd(40, "R6");
    rd(0, "R6"); rd(5, "R6"); rd(9, "R6"); rd(8, "R6");

    // R7: unmapped read and write
    rd(6, "R7"); rd(512, "R7"); rd(1021, "R7");
    wr(10, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    wr(1021, 64'h1234, "R7");
    wr(48, 64'hFFFF, "R7");
    rd(1022, "R7"); rd(1023, "R7"); rd(9, "R7"); rd(0, "R7");

    // R8: back-to-back reads then idle
    rd(1, "R8"); rd(2, "R8"); rd(257, "R8");
    idle("R8"); idle("R8");

    // R9: read and write in same cycle
    step(1'b1, 1'b1, 1, 64'hCAFE_F00D_CAFE_F00D, "R9"); rd(1, "R9");
    step(1'b1, 1'b1, 17, 64'h0000_0000_0000_00F0, "R9"); rd(1, "R9");
    step(1'b1, 1'b1, 700, 64'h1, "R9");

    // R8: mixed traffic
    for (int n = 0; n < 400; n++) begin
      int          ix;
      logic [63:0] d;
      bit          r, w;
      ix = pool[$urandom_range(pool.size() - 1)];
      d  = {$urandom, $urandom};
      r  = 1'($urandom);
      w  = 1'($urandom);
      step(r, w, ix, d, "R8");
    end
    foreach (mapped[k]) rd(mapped[k], "R8");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule